// File: doc/BRIEF.md
# Serial Scratchpad Memory Controller

This block holds the nine-byte scratchpad of a bit-serial sensor slave and carries out its memory commands. A byte-wide opcode arrives with a one-cycle strobe. Data then moves one bit per slot strobe. A write shifts the bit on `slotBitIn` into the scratchpad. A read consumes the bit presented on `slotBitOut`. The output always shows the bit that the next read slot will return, so the bus side can sample it before it strobes.

The scratchpad contents are as follows:
- Bytes 0 and 1 carry the latest temperature word and change only through the temperature-update input.
- Bytes 2 to 4 are the two alarm thresholds and the configuration byte. They are the only bytes a write command can change.
- Bytes 5 to 7 are reserved and fixed.
- Byte 8 is a CRC of everything sent before it.

A three-byte shadow bank stands in for nonvolatile storage. Commands can copy the writable bytes into it or recall them from it. Both operations take a parameterised number of cycles. A reset behaves as a power-up and reloads the writable bytes from the shadow bank with the same latency.

Top module: `scratchpad_ctrl`

## Requirements
- R1: After reset the block spends NV_CYCLES cycles reloading, and every read slot returns 0 during that time. After that, bytes 2, 3 and 4 equal bytes 0, 1 and 2 of SHADOW_INIT, and the shadow bank also starts from SHADOW_INIT.
- R2: Opcode 0xBE streams 72 bits, least significant bit first, from bit 0 of byte 0 through byte 8. Byte 0 is the temperature low byte and byte 1 is the temperature high byte. Read slots after the 72nd return 1.
- R3: Bytes 5, 6 and 7 always read 0xFF and no command alters them.
- R4: Byte 8 equals the CRC with polynomial x^8+x^5+x^4+1 (shift-right feedback constant 0x8C), initial value 0, fed bit-serially with the 64 bits of bytes 0 to 7 in sent order. The CRC over all 72 sent bits is therefore 0.
- R5: Opcode 0x4E takes 24 bits, least significant bit first, into byte 2, then byte 3, then byte 4. Slots after the 24th have no effect, and bytes 0, 1 and 5 to 7 are never written.
- R6: A cycle with `tempValid` high loads `tempIn[7:0]` into byte 0 and `tempIn[15:8]` into byte 1. No serial command changes them.
- R7: Opcode 0x48 keeps the block busy for NV_CYCLES cycles. At the end, the shadow bank takes bytes 2 to 4.
- R8: Opcode 0xB8 keeps the block busy for NV_CYCLES cycles, with read slots returning 0. It then loads bytes 2 to 4 from the shadow bank, and read slots return 1.
- R9: A command strobe or a `txnEnd` pulse ends an unfinished read or write. Bytes already completed keep their values and a partly received byte is discarded. If `cmdValid` and `txnEnd` are high in the same cycle, the command wins. A slot in the same cycle as either is ignored.
- R10: An opcode other than 0x4E, 0xBE, 0x48 and 0xB8 changes no storage. Commands that arrive while a copy or recall runs are ignored.
- R11: When no read or busy operation is in progress, read slots return 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, treated as power-up |
| cmdValid | input | 1 | Opcode strobe |
| cmdByte | input | 8 | Opcode |
| slotStrobe | input | 1 | One data slot per high cycle |
| slotBitIn | input | 1 | Bit written in a write slot |
| slotBitOut | output | 1 | Bit the next read slot returns |
| txnEnd | input | 1 | End-of-transaction pulse |
| tempValid | input | 1 | Temperature update strobe |
| tempIn | input | 16 | New temperature word |

## Verification
The write path is tried with several byte patterns: all zeros, all ones, alternating bits and irregular values. These separate bit-order and byte-order faults from stuck bits. Reads are taken after reset, after a temperature update, after full and truncated writes, and after copy and recall. This separates the reserved bytes, the CRC byte and the shadow path from the writable bytes. Interrupted transfers, unknown opcodes and commands issued during a copy show whether partial bytes or ignored commands leak into storage. The busy windows are compared slot by slot against a behavioural reference on every clock.

// File: rtl/spad_pkg.sv
package spad_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITE, ST_READ, ST_COPY, ST_RECALL
  } spState_e;

  localparam logic [7:0] OP_WRITE  = 8'h4E;
  localparam logic [7:0] OP_READ   = 8'hBE;
  localparam logic [7:0] OP_COPY   = 8'h48;
  localparam logic [7:0] OP_RECALL = 8'hB8;

  localparam int RW_FIRST  = 2;            // first writable byte
  localparam int RW_COUNT  = 3;            // writable bytes 2..4
  localparam int RW_LAST   = RW_FIRST + RW_COUNT - 1;
  localparam int CRC_INDEX = 8;            // last byte of a read
  localparam logic [7:0] CRC_FEEDBACK = 8'h8C; // x^8+x^5+x^4+1, reflected

  typedef struct packed {
    logic       reading;
    logic       busy;
    logic       crcClear;
    logic       wrShift;
    logic       wrCommit;
    logic       rdAdvance;
    logic       doCopy;
    logic       doRecall;
    logic [3:0] byteSel;
    logic [2:0] bitSel;
  } spCtrl_t;
endpackage

// File: rtl/spad_ctrl.sv
module spad_ctrl
  import spad_pkg::*;
#(
  parameter int NV_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdByte,
  input  logic       slotStrobe,
  input  logic       txnEnd,
  output spCtrl_t    ctl
);
  localparam int CW = (NV_CYCLES > 1) ? $clog2(NV_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(NV_CYCLES - 1);

  spState_e      state;
  logic [CW-1:0] cnt;
  logic [3:0]    byteIdx;
  logic [2:0]    bitIdx;
  logic          busy, slotTaken, knownOp;
  logic [3:0]    lastByte;

  assign busy      = (state == ST_COPY) || (state == ST_RECALL);
  assign slotTaken = slotStrobe && !cmdValid && !txnEnd;
  assign lastByte  = (state == ST_WRITE) ? 4'(RW_LAST) : 4'(CRC_INDEX);
  assign knownOp   = (cmdByte == OP_WRITE) || (cmdByte == OP_READ) ||
                     (cmdByte == OP_COPY)  || (cmdByte == OP_RECALL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RECALL;       // power-up reload
      cnt     <= CNT_LOAD;
      byteIdx <= '0;
      bitIdx  <= '0;
    end else if (busy) begin
      if (cnt == '0) state <= ST_IDLE;
      else           cnt   <= cnt - 1'b1;
    end else if (cmdValid) begin
      bitIdx <= '0;
      unique case (cmdByte)
        OP_WRITE:  begin state <= ST_WRITE;  byteIdx <= 4'(RW_FIRST); end
        OP_READ:   begin state <= ST_READ;   byteIdx <= '0;           end
        OP_COPY:   begin state <= ST_COPY;   cnt     <= CNT_LOAD;     end
        OP_RECALL: begin state <= ST_RECALL; cnt     <= CNT_LOAD;     end
        default:   state <= ST_IDLE;
      endcase
    end else if (txnEnd) begin
      state <= ST_IDLE;
    end else if (slotStrobe && (state == ST_WRITE || state == ST_READ)) begin
      bitIdx <= bitIdx + 1'b1;
      if (bitIdx == 3'd7) begin
        if (byteIdx == lastByte) state <= ST_IDLE;
        else                     byteIdx <= byteIdx + 1'b1;
      end
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.busy      = busy;
    ctl.reading   = (state == ST_READ);
    ctl.crcClear  = !busy && cmdValid && (cmdByte == OP_READ);
    ctl.wrShift   = (state == ST_WRITE) && slotTaken;
    ctl.wrCommit  = (state == ST_WRITE) && slotTaken && (bitIdx == 3'd7);
    ctl.rdAdvance = (state == ST_READ) && slotTaken;
    ctl.doCopy    = (state == ST_COPY) && (cnt == '0);
    ctl.doRecall  = (state == ST_RECALL) && (cnt == '0);
    ctl.byteSel   = byteIdx;
    ctl.bitSel    = bitIdx;
  end

  // R8: a finished copy or recall always returns to idle
  p_busy_exit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt == '0) |=> (state == ST_IDLE));
  // R10: commands are ignored while the counter runs
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != '0) |=> (state == $past(state)));
  // R10: an unknown opcode leaves the controller idle
  p_unknown_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid && !knownOp) |=> (state == ST_IDLE));
  // R9: end-of-transaction closes any transfer
  p_txn_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cmdValid && txnEnd) |=> (state == ST_IDLE));
endmodule

// File: rtl/spad_dpath.sv
module spad_dpath
  import spad_pkg::*;
#(
  parameter logic [8*RW_COUNT-1:0] SHADOW_INIT = '0,
  parameter logic [15:0]           TEMP_INIT   = 16'h0550
) (
  input  logic        clk,
  input  logic        rstN,
  input  spCtrl_t     ctl,
  input  logic        slotBitIn,
  input  logic        tempValid,
  input  logic [15:0] tempIn,
  output logic        slotBitOut
);
  logic [15:0] tempReg;
  logic [7:0]  rwByte [RW_COUNT];
  logic [7:0]  shadow [RW_COUNT];
  logic [6:0]  shiftReg;
  logic [7:0]  crcReg;
  logic [7:0]  curByte;
  logic        curBit, fb;
  logic [8*RW_COUNT-1:0] rwFlat, shFlat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          tempReg <= TEMP_INIT;
    else if (tempValid) tempReg <= tempIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            shiftReg <= '0;
    else if (ctl.wrShift) shiftReg <= {slotBitIn, shiftReg[6:1]};
  end

  for (genvar g = 0; g < RW_COUNT; g++) begin : g_rw
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             rwByte[g] <= '0;
      else if (ctl.doRecall) rwByte[g] <= shadow[g];
      else if (ctl.wrCommit && ctl.byteSel == 4'(g + RW_FIRST))
        rwByte[g] <= {slotBitIn, shiftReg};
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           shadow[g] <= SHADOW_INIT[8*g +: 8];
      else if (ctl.doCopy) shadow[g] <= rwByte[g];
    end
    assign rwFlat[8*g +: 8] = rwByte[g];
    assign shFlat[8*g +: 8] = shadow[g];
  end

  always_comb begin
    if (ctl.byteSel == 4'd0)                 curByte = tempReg[7:0];
    else if (ctl.byteSel == 4'd1)            curByte = tempReg[15:8];
    else if (ctl.byteSel <= 4'(RW_LAST))     curByte = rwByte[ctl.byteSel - 4'(RW_FIRST)];
    else if (ctl.byteSel < 4'(CRC_INDEX))    curByte = 8'hFF;
    else                                     curByte = crcReg;
  end
  assign curBit     = curByte[ctl.bitSel];
  assign fb         = crcReg[0] ^ curBit;
  assign slotBitOut = ctl.reading ? curBit : !ctl.busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            crcReg <= '0;
    else if (ctl.crcClear) crcReg <= '0;
    else if (ctl.rdAdvance && ctl.byteSel < 4'(CRC_INDEX))
      crcReg <= (crcReg >> 1) ^ (fb ? CRC_FEEDBACK : 8'h00);
  end

  // R3: reserved bytes stream ones
  p_res_ones_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.reading && ctl.byteSel > 4'(RW_LAST) && ctl.byteSel < 4'(CRC_INDEX)) |-> slotBitOut);
  // R6: temperature bytes move only on an update strobe
  p_temp_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !tempValid |=> $stable(tempReg));
  // R5: writable bytes move only on a commit or a recall
  p_rw_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.wrCommit || ctl.doRecall) |=> $stable(rwFlat));
  // R7: shadow bank moves only at the end of a copy
  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.doCopy |=> $stable(shFlat));
  // R8: recall loads the shadow contents
  p_recall_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doRecall |=> (rwFlat == $past(shFlat)));
endmodule

// File: rtl/scratchpad_ctrl.sv
module scratchpad_ctrl
  import spad_pkg::*;
#(
  parameter int                    NV_CYCLES   = 16,
  parameter logic [8*RW_COUNT-1:0] SHADOW_INIT = 24'h7F_E6_4B,
  parameter logic [15:0]           TEMP_INIT   = 16'h0550
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [7:0]  cmdByte,
  input  logic        slotStrobe,
  input  logic        slotBitIn,
  output logic        slotBitOut,
  input  logic        txnEnd,
  input  logic        tempValid,
  input  logic [15:0] tempIn
);
  spCtrl_t ctl;

  spad_ctrl #(.NV_CYCLES(NV_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .slotStrobe(slotStrobe), .txnEnd(txnEnd), .ctl(ctl)
  );

  spad_dpath #(.SHADOW_INIT(SHADOW_INIT), .TEMP_INIT(TEMP_INIT)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .slotBitIn(slotBitIn),
    .tempValid(tempValid), .tempIn(tempIn), .slotBitOut(slotBitOut)
  );
endmodule

// File: tb/test_scratchpad_ctrl.sv
`timescale 1ns/1ps
module test_scratchpad_ctrl;
  localparam int          NV     = 16;
  localparam logic [23:0] SH_INI = 24'h7F_E6_4B;
  localparam logic [15:0] T_INI  = 16'h0550;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 0, slotStrobe = 0, slotBitIn = 0, txnEnd = 0, tempValid = 0;
  logic [7:0]  cmdByte = 0;
  logic [15:0] tempIn = 0;
  logic slotBitOut;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  scratchpad_ctrl #(.NV_CYCLES(NV), .SHADOW_INIT(SH_INI), .TEMP_INIT(T_INI)) i_scratchpad_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .slotStrobe(slotStrobe), .slotBitIn(slotBitIn), .slotBitOut(slotBitOut),
    .txnEnd(txnEnd), .tempValid(tempValid), .tempIn(tempIn));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crcOf(logic [7:0] b [9], int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) begin
        logic f = c[0] ^ b[i][k];
        c = c >> 1;
        if (f) c = c ^ 8'h8C;
      end
    return c;
  endfunction

  // ---------------- behavioural reference ----------------
  int mMode;            // 0 idle, 1 write, 2 read, 3 copy, 4 recall
  int mCnt, wCnt;
  logic [7:0] wAcc;
  logic [7:0] mRw [3];
  logic [7:0] mSh [3];
  logic [15:0] mTemp;
  bit mQ [$];

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 4; mCnt = NV - 1; mTemp = T_INI; mQ.delete();
      for (int i = 0; i < 3; i++) begin mRw[i] = 8'h00; mSh[i] = SH_INI[8*i +: 8]; end
    end else begin
      if (mMode >= 3) begin
        if (mCnt == 0) begin
          for (int i = 0; i < 3; i++)
            if (mMode == 3) mSh[i] = mRw[i]; else mRw[i] = mSh[i];
          mMode = 0;
        end else mCnt--;
      end else if (cmdValid) begin
        mQ.delete();
        case (cmdByte)
          8'h4E: begin mMode = 1; wCnt = 0; end
          8'hBE: begin
            logic [7:0] img [9];
            mMode = 2;
            img[0] = mTemp[7:0]; img[1] = mTemp[15:8];
            for (int i = 0; i < 3; i++) img[2+i] = mRw[i];
            for (int i = 5; i < 8; i++) img[i] = 8'hFF;
            img[8] = crcOf(img, 8);
            for (int i = 0; i < 9; i++) for (int k = 0; k < 8; k++) mQ.push_back(img[i][k]);
          end
          8'h48: begin mMode = 3; mCnt = NV - 1; end
          8'hB8: begin mMode = 4; mCnt = NV - 1; end
          default: mMode = 0;
        endcase
      end else if (txnEnd) begin
        mMode = 0; mQ.delete();
      end else if (slotStrobe && mMode == 1) begin
        wAcc = {slotBitIn, wAcc[7:1]}; wCnt++;
        if (wCnt % 8 == 0) mRw[wCnt/8 - 1] = wAcc;
        if (wCnt == 24) mMode = 0;
      end else if (slotStrobe && mMode == 2) begin
        void'(mQ.pop_front());
        if (mQ.size() == 0) mMode = 0;
      end
      if (tempValid) mTemp = tempIn;
    end
  end

  // every-clock comparison of the slot output
  always @(negedge clk) if (rstN) begin
    if (mMode == 2)      chk("R2 read bit", slotBitOut, mQ[0]);
    else if (mMode >= 3) chk("R8 busy slot", slotBitOut, 0);
    else                 chk("R11 idle slot", slotBitOut, 1);
  end

  // ---------------- stimulus tasks (entered at negedge) ----------------
  task automatic sendCmd(logic [7:0] op);
    cmdValid = 1; cmdByte = op; @(negedge clk); cmdValid = 0;
  endtask
  task automatic wrSlot(logic v);
    slotBitIn = v; slotStrobe = 1; @(negedge clk); slotStrobe = 0;
  endtask
  task automatic rdSlot(output logic b);
    b = slotBitOut; slotStrobe = 1; @(negedge clk); slotStrobe = 0;
  endtask
  task automatic writeBytes(logic [23:0] v);
    sendCmd(8'h4E);
    for (int i = 0; i < 24; i++) wrSlot(v[i]);
  endtask
  task automatic readAll(output logic [7:0] b [9]);
    logic x;
    sendCmd(8'hBE);
    for (int i = 0; i < 9; i++) for (int k = 0; k < 8; k++) begin rdSlot(x); b[i][k] = x; end
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic expectRw(string req, logic [7:0] b [9], logic [23:0] exp);
    chk(req, {b[4], b[3], b[2]}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] b [9];
    logic x;
    repeat (3) @(negedge clk);
    rstN = 1;
    chk("R1 reload busy", slotBitOut, 0);
    idle(NV + 2);
    chk("R1 reload done", slotBitOut, 1);
    readAll(b);
    expectRw("R1 reloaded bytes", b, SH_INI);
    chk("R2 temperature bytes", {b[1], b[0]}, T_INI);
    chk("R3 reserved bytes", {b[7], b[6], b[5]}, 24'hFFFFFF);
    chk("R4 crc byte", b[8], crcOf(b, 8));
    chk("R4 crc residue", crcOf(b, 9), 0);
    rdSlot(x);
    chk("R2 past end", x, 1);

    // R6: temperature update
    tempIn = 16'h1234; tempValid = 1; @(negedge clk); tempValid = 0;
    readAll(b);
    chk("R6 temp update", {b[1], b[0]}, 16'h1234);
    chk("R4 crc after temp", crcOf(b, 9), 0);

    // R5: several write patterns
    writeBytes(24'h000000); readAll(b); expectRw("R5 zeros", b, 24'h000000);
    writeBytes(24'hFFFFFF); readAll(b); expectRw("R5 ones", b, 24'hFFFFFF);
    writeBytes(24'h55AA55); readAll(b); expectRw("R5 alternating", b, 24'h55AA55);
    writeBytes(24'h7F3CA5);
    for (int i = 0; i < 8; i++) wrSlot(1'b0);   // extra slots: no effect
    readAll(b);
    expectRw("R5 write order", b, 24'h7F3CA5);
    chk("R6 temp untouched by write", {b[1], b[0]}, 16'h1234);
    chk("R3 reserved after write", {b[7], b[6], b[5]}, 24'hFFFFFF);

    // R7/R8: copy, overwrite, recall
    sendCmd(8'h48);
    chk("R7 copy busy", slotBitOut, 0);
    idle(NV + 1);
    writeBytes(24'h112233);
    sendCmd(8'hB8);
    for (int i = 0; i < NV - 1; i++) begin rdSlot(x); chk("R8 recall busy", x, 0); end
    idle(2);
    rdSlot(x); chk("R8 recall done", x, 1);
    readAll(b);
    expectRw("R7 R8 shadow round trip", b, 24'h7F3CA5);

    // R9: truncated write by txnEnd
    sendCmd(8'h4E);
    for (int i = 0; i < 11; i++) wrSlot(i < 8 ? (8'hC3 >> i) & 1 : 1'b0);
    txnEnd = 1; @(negedge clk); txnEnd = 0;
    readAll(b);
    expectRw("R9 partial by end", b, 24'h7F3CC3);
    // R9: truncated write by new command
    sendCmd(8'h4E);
    for (int i = 0; i < 20; i++) wrSlot(1'b1);
    sendCmd(8'h00);
    readAll(b);
    expectRw("R9 partial by cmd", b, 24'h7FFFFF);
    // R9: read cut short then restarted
    sendCmd(8'hBE);
    for (int i = 0; i < 12; i++) rdSlot(x);
    readAll(b);
    chk("R9 restarted read", {b[1], b[0]}, 16'h1234);

    // R10: unknown opcode and commands during copy
    sendCmd(8'h33);
    for (int i = 0; i < 24; i++) wrSlot(1'b0);
    readAll(b);
    expectRw("R10 unknown opcode", b, 24'h7FFFFF);
    sendCmd(8'h48);
    sendCmd(8'h4E);
    for (int i = 0; i < 24; i++) wrSlot(1'b0);
    readAll(b);
    expectRw("R10 command while busy", b, 24'h7FFFFF);
    idle(4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule